// File: doc/BRIEF.md
# Lockable GPIO Register File

This block holds the configuration and status words for a port of general-purpose pins, one bit per pin. The external pin and event logic uses these words. Software reaches them over a simple synchronous bus. Plain read/write words hold the output level, output enable, event enable, event kind, both-edge select, polarity, pull-up, pull-down, slew and drive settings. Output level, output enable and event enable each also have a set-only alias address and a clear-only alias address. The event status word collects event flags from the external detector and is cleared one bit at a time by writing ones. The input word returns the live pin levels and cannot be written.

A two-word lock protects the configuration. Writing the lock key to the first lock word freezes every write except those to the lock words. Only a second key, already placed in the second lock word, followed by any write to the first lock word, releases the port. Illegal accesses raise a one-cycle error pulse. Read data and the error both appear one cycle after the access.

Top module: `gpio_lock_regs`

## Requirements
- R1: After reset, the pull-up, pull-down, slew and drive words hold the per-pin parameter values `RST_PULL_UP`, `RST_PULL_DN`, `RST_SLEW` and `RST_DRIVE`, and every other stored word reads zero.
- R2: Word addresses: 0 input, 1 output level, 2/3 its set/clear aliases, 4 output enable, 5/6 its aliases, 7 event enable, 8/9 its aliases, 10 event status, 11 event kind, 12 both-edge, 13 polarity, 14 pull-up, 15 pull-down, 16 slew, 17 drive, 18 lock A, 19 lock B. 20 and above are unmapped. A read on cycle n returns data on `rdata_o` after the edge that ends cycle n, and plain words read back what was last written.
- R3: While unlocked, a write to a set alias ORs the write data into its target word, and a write to a clear alias clears the target bits written as one.
- R4: Each `evt_set_i` bit that is high in a cycle sets that event status bit. A write to address 10 clears the bits written as one. A set and a clear of the same bit in one cycle leaves the bit set.
- R5: While unlocked, writing `LOCK_KEY` (default 32'hC0DEFEED) to lock A loads lock A with 1 and lock B with 0. Any other value is stored in lock A as written. The port is locked whenever lock A holds 1.
- R6: While locked, writes to every address other than 18 and 19 change no stored word, including the aliases and the event status clear. Lock B stays writable.
- R7: While locked, a write to lock A clears both lock words if lock B holds `UNLOCK_KEY` (default 32'h5A5A5A5A). Otherwise the write changes nothing.
- R8: A write to address 0 is ignored and flags an error. A read of an alias address (2, 3, 5, 6, 8, 9) returns zero and flags an error. Any access to an unmapped address flags an error, and an unmapped read returns zero. `err_o` is high for exactly the one cycle after the access, whether or not the port is locked.
- R9: A read of address 0 returns the value on `pin_in_i` in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | NPINS | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | NPINS | Read data, one cycle after the read |
| err_o | output | 1 | Illegal-access pulse |
| pin_in_i | input | NPINS | Resolved pin levels |
| evt_set_i | input | NPINS | Event flags from the detector |
| out_data_o | output | NPINS | Output level word |
| out_en_o | output | NPINS | Output enable word |
| evt_en_o | output | NPINS | Event enable word |
| evt_stat_o | output | NPINS | Event status word |
| evt_kind_o | output | NPINS | Event kind word |
| evt_both_o | output | NPINS | Both-edge select word |
| polarity_o | output | NPINS | Polarity word |
| pull_up_o | output | NPINS | Pull-up word |
| pull_dn_o | output | NPINS | Pull-down word |
| slew_o | output | NPINS | Slew word |
| drive_o | output | NPINS | Drive word |

## Verification
The bench sweeps all 32 addresses for reads after reset and for writes while locked. A decoder with a wrong legal-address set would show up as a missing or extra error pulse, or as a nonzero read from an alias or hole. Locking is checked against every address. A lock gate that misses the aliases or the status clear would let a frozen word change, and a wrong unlock condition would release the port without the key or keep it locked with the key. A status register that lets the clear win over a new event would drop that event when the two arrive in the same cycle.

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs #(
  parameter int NPINS = 32,
  parameter int ADDR_W = 5,
  parameter logic [NPINS-1:0] RST_PULL_UP = '0,
  parameter logic [NPINS-1:0] RST_PULL_DN = '0,
  parameter logic [NPINS-1:0] RST_SLEW    = '0,
  parameter logic [NPINS-1:0] RST_DRIVE   = '0,
  parameter logic [NPINS-1:0] LOCK_KEY    = 32'hC0DEFEED,
  parameter logic [NPINS-1:0] UNLOCK_KEY  = 32'h5A5A5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              err_o,
  input  logic [NPINS-1:0]  pin_in_i,
  input  logic [NPINS-1:0]  evt_set_i,
  output logic [NPINS-1:0]  out_data_o,
  output logic [NPINS-1:0]  out_en_o,
  output logic [NPINS-1:0]  evt_en_o,
  output logic [NPINS-1:0]  evt_stat_o,
  output logic [NPINS-1:0]  evt_kind_o,
  output logic [NPINS-1:0]  evt_both_o,
  output logic [NPINS-1:0]  polarity_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o,
  output logic [NPINS-1:0]  slew_o,
  output logic [NPINS-1:0]  drive_o
);

  localparam logic [ADDR_W-1:0] A_PIN    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OD     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OD_SET = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OD_CLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OE     = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OE_SET = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_OE_CLR = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_EE     = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_EE_SET = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_EE_CLR = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_ES     = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_KIND   = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_BOTH   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_PU     = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_PD     = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_SLEW   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_DRV    = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_LKA    = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] A_LKB    = ADDR_W'(19);
  localparam logic [NPINS-1:0]  ONE      = NPINS'(1);

  logic [NPINS-1:0] od, oe, ee, es, kind, both, pol, pu, pd, slew, drv, lka, lkb;
  logic [NPINS-1:0] rmux;
  logic             locked, wr_ok, rd_legal, wr_legal, alias_a;

  assign locked = (lka == ONE);
  assign wr_ok  = wr_en_i && !locked;

  assign alias_a = (addr_i == A_OD_SET) || (addr_i == A_OD_CLR) ||
                   (addr_i == A_OE_SET) || (addr_i == A_OE_CLR) ||
                   (addr_i == A_EE_SET) || (addr_i == A_EE_CLR);
  assign wr_legal = (addr_i != A_PIN) && (addr_i <= A_LKB);
  assign rd_legal = !alias_a && (addr_i <= A_LKB);

  always_comb begin
    unique case (addr_i)
      A_PIN:   rmux = pin_in_i;
      A_OD:    rmux = od;
      A_OE:    rmux = oe;
      A_EE:    rmux = ee;
      A_ES:    rmux = es;
      A_KIND:  rmux = kind;
      A_BOTH:  rmux = both;
      A_POL:   rmux = pol;
      A_PU:    rmux = pu;
      A_PD:    rmux = pd;
      A_SLEW:  rmux = slew;
      A_DRV:   rmux = drv;
      A_LKA:   rmux = lka;
      A_LKB:   rmux = lkb;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od <= '0; oe <= '0; ee <= '0; kind <= '0; both <= '0; pol <= '0;
      pu <= RST_PULL_UP; pd <= RST_PULL_DN; slew <= RST_SLEW; drv <= RST_DRIVE;
    end else if (wr_ok) begin
      case (addr_i)
        A_OD:     od   <= wdata_i;
        A_OD_SET: od   <= od | wdata_i;
        A_OD_CLR: od   <= od & ~wdata_i;
        A_OE:     oe   <= wdata_i;
        A_OE_SET: oe   <= oe | wdata_i;
        A_OE_CLR: oe   <= oe & ~wdata_i;
        A_EE:     ee   <= wdata_i;
        A_EE_SET: ee   <= ee | wdata_i;
        A_EE_CLR: ee   <= ee & ~wdata_i;
        A_KIND:   kind <= wdata_i;
        A_BOTH:   both <= wdata_i;
        A_POL:    pol  <= wdata_i;
        A_PU:     pu   <= wdata_i;
        A_PD:     pd   <= wdata_i;
        A_SLEW:   slew <= wdata_i;
        A_DRV:    drv  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) es <= '0;
    else es <= (es & ~((wr_ok && addr_i == A_ES) ? wdata_i : '0)) | evt_set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lka <= '0;
      lkb <= '0;
    end else if (wr_en_i && addr_i == A_LKB) begin
      lkb <= wdata_i;
    end else if (wr_en_i && addr_i == A_LKA) begin
      if (locked) begin
        if (lkb == UNLOCK_KEY) begin
          lka <= '0;
          lkb <= '0;
        end
      end else if (wdata_i == LOCK_KEY) begin
        lka <= ONE;
        lkb <= '0;
      end else begin
        lka <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_legal ? rmux : '0;
      err_o <= (rd_en_i && !rd_legal) || (wr_en_i && !wr_legal);
    end
  end

  assign out_data_o = od;
  assign out_en_o   = oe;
  assign evt_en_o   = ee;
  assign evt_stat_o = es;
  assign evt_kind_o = kind;
  assign evt_both_o = both;
  assign polarity_o = pol;
  assign pull_up_o  = pu;
  assign pull_dn_o  = pd;
  assign slew_o     = slew;
  assign drive_o    = drv;

  // R6
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_en_i && addr_i != A_LKA && addr_i != A_LKB |=>
      $stable(od) && $stable(oe) && $stable(ee) && $stable(kind) && $stable(both) &&
      $stable(pol) && $stable(pu) && $stable(pd) && $stable(slew) && $stable(drv) && $stable(lka));

  // R7
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_en_i && addr_i == A_LKA && lkb == UNLOCK_KEY |=> lka == '0 && lkb == '0);

  // R3
  od_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && wr_en_i && addr_i == A_OD_SET |=> od == ($past(od) | $past(wdata_i)));

  // R4
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (es & $past(evt_set_i)) == $past(evt_set_i));

  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && addr_i > A_LKB |=> err_o && rdata_o == '0);

  // R8
  pin_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i == A_PIN |=> err_o);

endmodule

// File: tb/tb_gpio_lock_regs.sv
module tb_gpio_lock_regs;
  localparam logic [31:0] PU  = 32'h0000_00FF;
  localparam logic [31:0] PD  = 32'hFF00_0000;
  localparam logic [31:0] SLW = 32'h0F0F_0000;
  localparam logic [31:0] DRV = 32'h0000_3C3C;
  localparam logic [31:0] KEY = 32'hC0DEFEED;
  localparam logic [31:0] UNK = 32'h5A5A5A5A;
  localparam logic [31:0] PIN = 32'hA5A5_0F0F;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, err_o;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata_o, evt_set = '0;
  logic [31:0] od_o, oe_o, ee_o, es_o, kind_o, both_o, pol_o, pu_o, pd_o, slew_o, drv_o;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_lock_regs #(.RST_PULL_UP(PU), .RST_PULL_DN(PD), .RST_SLEW(SLW), .RST_DRIVE(DRV)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .rdata_o(rdata_o), .err_o(err_o), .pin_in_i(PIN), .evt_set_i(evt_set),
    .out_data_o(od_o), .out_en_o(oe_o), .evt_en_o(ee_o), .evt_stat_o(es_o),
    .evt_kind_o(kind_o), .evt_both_o(both_o), .polarity_o(pol_o), .pull_up_o(pu_o),
    .pull_dn_o(pd_o), .slew_o(slew_o), .drive_o(drv_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic e);
    @(negedge clk); addr = a[4:0]; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; e = err_o;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic e);
    @(negedge clk); addr = a[4:0]; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata_o; e = err_o;
  endtask

  function automatic logic [31:0] port_of(input int a);
    case (a)
      1: return od_o;    4: return oe_o;    7: return ee_o;    11: return kind_o;
      12: return both_o; 13: return pol_o;  14: return pu_o;   15: return pd_o;
      16: return slew_o; 17: return drv_o;  default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int k);
    return (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << k);
  endfunction

  function automatic bit is_alias(input int a);
    return a == 2 || a == 3 || a == 5 || a == 6 || a == 8 || a == 9;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, base, exp;
    logic e;
    int rw_addr[11] = '{1, 4, 7, 11, 12, 13, 14, 15, 16, 17, 19};
    int tgt[3] = '{1, 4, 7};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 R2 R8 R9: read sweep after reset
    for (int a = 0; a < 32; a++) begin
      rd(a, d, e);
      if (a == 0) exp = PIN;
      else if (a == 14) exp = PU;
      else if (a == 15) exp = PD;
      else if (a == 16) exp = SLW;
      else if (a == 17) exp = DRV;
      else exp = '0;
      chk($sformatf("R1 reset read a=%0d", a), d, exp);
      chk($sformatf("R8 read err a=%0d", a), {31'd0, e}, {31'd0, (a > 19) || is_alias(a)});
    end
    @(negedge clk);
    chk("R8 err pulse one cycle", {31'd0, err_o}, 32'd0);

    // R2: plain read/write sweep
    for (int i = 0; i < 11; i++)
      for (int k = 0; k < 8; k++) begin
        wr(rw_addr[i], pat(k + i), e);
        rd(rw_addr[i], d, e);
        chk($sformatf("R2 readback a=%0d", rw_addr[i]), d, pat(k + i));
        if (rw_addr[i] != 19)
          chk($sformatf("R2 port a=%0d", rw_addr[i]), port_of(rw_addr[i]), pat(k + i));
      end

    // R3: set/clear aliases
    for (int t = 0; t < 3; t++)
      for (int k = 0; k < 4; k++) begin
        base = pat(k) & 32'h0F0F_F0F0;
        wr(tgt[t], base, e);
        wr(tgt[t] + 1, pat(k + 5), e);
        exp = base | pat(k + 5);
        chk($sformatf("R3 set a=%0d", tgt[t]), port_of(tgt[t]), exp);
        wr(tgt[t] + 2, pat(k + 9), e);
        exp = exp & ~pat(k + 9);
        rd(tgt[t], d, e);
        chk($sformatf("R3 clear a=%0d", tgt[t]), d, exp);
      end

    // R4: event status
    @(negedge clk); evt_set = 32'h8000_00F1;
    @(negedge clk); evt_set = 32'h0000_0300;
    @(negedge clk); evt_set = '0;
    rd(10, d, e);
    chk("R4 event accumulate", d, 32'h8000_03F1);
    wr(10, 32'h8000_0011, e);
    chk("R4 w1c", es_o, 32'h0000_03E0);
    @(negedge clk); addr = 5'd10; wdata = 32'h0000_0320; wr_en = 1; evt_set = 32'h0000_0020;
    @(negedge clk); wr_en = 0; evt_set = '0;
    chk("R4 set beats clear", es_o, 32'h0000_00E0);

    // R8 R9: write to input word
    wr(0, 32'hFFFF_FFFF, e);
    chk("R8 input write err", {31'd0, e}, 32'd1);
    rd(0, d, e);
    chk("R9 input read", d, PIN);

    // R5: non-key value stored in lock A
    wr(18, 32'h0000_0033, e);
    rd(18, d, e);
    chk("R5 lockA plain", d, 32'h33);
    wr(1, 32'h1234_5678, e);
    chk("R5 not locked", od_o, 32'h1234_5678);

    // preload known values
    for (int i = 0; i < 10; i++) wr(rw_addr[i], 32'h1111_1111 * (i + 1), e);
    wr(19, 32'h0000_BEEF, e);
    wr(18, KEY, e);
    rd(18, d, e);
    chk("R5 lockA after key", d, 32'd1);
    rd(19, d, e);
    chk("R5 lockB cleared", d, 32'd0);

    // R6 R8: locked write sweep
    for (int a = 0; a < 32; a++)
      if (a != 18 && a != 19) begin
        wr(a, 32'hFFFF_FFFF, e);
        chk($sformatf("R8 locked err a=%0d", a), {31'd0, e}, {31'd0, (a == 0) || (a > 19)});
      end
    for (int i = 0; i < 10; i++) begin
      rd(rw_addr[i], d, e);
      chk($sformatf("R6 frozen a=%0d", rw_addr[i]), d, 32'h1111_1111 * (i + 1));
    end
    chk("R6 status clear ignored", es_o, 32'h0000_00E0);

    // R7: unlock rules
    wr(18, KEY, e);
    rd(18, d, e);
    chk("R7 no key stays locked", d, 32'd1);
    wr(19, 32'h5A5A_5A5B, e);
    wr(18, 32'd0, e);
    rd(18, d, e);
    chk("R7 wrong key stays locked", d, 32'd1);
    rd(19, d, e);
    chk("R6 lockB writable", d, 32'h5A5A_5A5B);
    wr(19, UNK, e);
    wr(18, 32'h0000_0007, e);
    rd(18, d, e);
    chk("R7 unlocked lockA", d, 32'd0);
    rd(19, d, e);
    chk("R7 unlocked lockB", d, 32'd0);
    wr(1, 32'hCAFE_0001, e);
    chk("R7 writes effective", od_o, 32'hCAFE_0001);

    // R5: writing 1 directly locks
    wr(18, 32'd1, e);
    wr(2, 32'hFFFF_0000, e);
    chk("R5 lock via 1", od_o, 32'hCAFE_0001);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule